// File: doc/BRIEF.md
# One-Shot Indexed Extended Register Port

This block is a bank of 8-bit extended configuration registers. A host reaches the bank through two I/O addresses. The first address is the index port, at 0x1CE by default or at 0x3CE when `ALT_BASE` is set. The second is the data port, one address above it. The host selects a register by writing its index to the index port. It then reads or writes that register with one byte access to the data port. An index serves exactly one data-port access, and a second access needs a fresh index. A 16-bit write to the index port carries an index and a data byte together, so it completes a register write in one bus cycle. Every register value is also driven onto a flat output bus, where downstream logic can use it directly.

The number of registers, `NREGS`, is a parameter and may be 16, 32 or 64. Whatever the size, the top 16 physical registers answer at indices 0xB0 through 0xBF. Smaller physical numbers sit at the indices just below that window. The host bus uses a single-cycle strobe. A write takes effect on the clock edge at the end of its strobe cycle. Read data is combinational during the strobe cycle.

The sequencing is a two-state machine. In `ST_IDLE` no index is held. In `ST_ARMED` one index is held for one access. The transitions are:
- `T_ARM`: from `ST_IDLE` to `ST_ARMED`, on a byte write to the index port.
- `T_REARM`: from `ST_ARMED` to `ST_ARMED`, on a byte write to the index port; the new index replaces the old one.
- `T_CONSUME`: from `ST_ARMED` to `ST_IDLE`, on any data-port read or write.
- `T_DIRECT`: from either state to `ST_IDLE`, on a 16-bit write to the index port.
- `T_STRAY`: from `ST_IDLE` to `ST_IDLE`, on a data-port access without an armed index; this access is ignored.

Top module: `oneshot_xreg_port`

## Requirements
- R1: The index port is at 0x1CE (0x3CE when `ALT_BASE`=1) and the data port is at the index port plus one. Writes to any other address have no effect. Reads from any other address return 0xFF.
- R2: A write to the index port with `be`=2'b11 uses `wdata[7:0]` as the index and `wdata[15:8]` as the data. It writes that register on the strobe's clock edge and leaves the port unarmed.
- R3: A byte write (`be`=2'b01, value on `wdata[7:0]`) to the index port arms that index. A following byte write to the data port stores `wdata[7:0]` in the indexed register on that strobe's clock edge.
- R4: After an index is armed, a read strobe at the data port returns the indexed register on `rdata` combinationally in the same cycle.
- R5: One data-port access, read or write, disarms the index. This holds even when the index is out of range.
- R6: A data-port write while no index is armed changes no register.
- R7: A data-port read while no index is armed returns 0xFF and leaves the port unarmed.
- R8: Physical register p answers at index 0xC0 − `NREGS` + p. The last 16 physical registers are therefore always at 0xB0–0xBF.
- R9: An index outside the implemented range reads as 0xFF, and writes to it change no register.
- R10: After reset every register is 0x00 and no index is armed.
- R11: Register p is driven on `regs_o[8p+7:8p]`.
- R12: A byte write to the index port while an index is already armed replaces the armed index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | I/O address of the current strobe |
| wdata | input | 16 | Write data; a byte access uses bits 7:0 |
| be | input | 2 | Byte enables: 2'b01 for a byte access, 2'b11 for a 16-bit access |
| wr | input | 1 | Single-cycle write strobe |
| rd | input | 1 | Single-cycle read strobe |
| rdata | output | 8 | Read data; 0xFF when no register is addressed |
| regs_o | output | 8*NREGS | All register contents, register p in byte lane p |

## Verification
The assertions assume that `wr` and `rd` are never high in the same cycle. They also assume that every strobe lasts exactly one clock cycle with its address, data and byte enables stable during it. The bench's access tasks raise exactly one strobe at a falling edge and drop it at the next falling edge. Between tasks the bus is idle, so the assumptions hold throughout. The bench covers all 256 index values in each access mode. It keeps its own model of the 32-register bank. It compares the model against both the read port and the register output bus.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_ARMED
    } port_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_IDX_SET,
        CMD_DIRECT,
        CMD_DATA_WR,
        CMD_DATA_RD
    } host_cmd_e;

    localparam logic [15:0] PRIMARY_BASE = 16'h01CE;
    localparam logic [15:0] ALTERNATE_BASE = 16'h03CE;
    localparam logic [7:0]  NO_DATA = 8'hFF;
    localparam int          WINDOW_END = 192;

endpackage

// File: rtl/xreg_decode.sv
module xreg_decode
    import xreg_pkg::*;
#(
    parameter logic [15:0] BASE = 16'h01CE
) (
    input  logic [15:0] addr,
    input  logic [1:0]  be,
    input  logic        wr,
    input  logic        rd,
    output host_cmd_e   cmd
);
    localparam logic [15:0] DATA_ADDR = BASE + 16'd1;

    always_comb begin
        cmd = CMD_NONE;
        if (wr) begin
            if (addr == BASE) begin
                if (be == 2'b11)
                    cmd = CMD_DIRECT;
                else if (be == 2'b01)
                    cmd = CMD_IDX_SET;
            end else if (addr == DATA_ADDR && be == 2'b01) begin
                cmd = CMD_DATA_WR;
            end
        end else if (rd && addr == DATA_ADDR) begin
            cmd = CMD_DATA_RD;
        end
    end

endmodule

// File: rtl/xreg_fsm.sv
module xreg_fsm
    import xreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  host_cmd_e   cmd,
    input  logic [15:0] wdata,
    output port_state_e state,
    output logic        bank_we,
    output logic [7:0]  bank_widx,
    output logic [7:0]  bank_wdata,
    output logic        rd_valid,
    output logic [7:0]  rd_idx
);
    port_state_e state_d;
    logic [7:0]  idx_q;
    logic [7:0]  idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_q <= 8'h00;
        end else begin
            state <= state_d;
            idx_q <= idx_d;
        end
    end

    // next state: T_ARM, T_REARM, T_CONSUME, T_DIRECT, T_STRAY
    always_comb begin
        state_d = state;
        idx_d   = idx_q;
        unique case (state)
            ST_IDLE: begin
                if (cmd == CMD_IDX_SET) begin
                    state_d = ST_ARMED;
                    idx_d   = wdata[7:0];
                end
            end
            ST_ARMED: begin
                if (cmd == CMD_IDX_SET) begin
                    idx_d = wdata[7:0];
                end else if (cmd == CMD_DATA_WR || cmd == CMD_DATA_RD ||
                             cmd == CMD_DIRECT) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // outputs toward the bank
    always_comb begin
        bank_we    = 1'b0;
        bank_widx  = idx_q;
        bank_wdata = wdata[7:0];
        rd_valid   = 1'b0;
        rd_idx     = idx_q;
        unique case (state)
            ST_IDLE: begin
                if (cmd == CMD_DIRECT) begin
                    bank_we    = 1'b1;
                    bank_widx  = wdata[7:0];
                    bank_wdata = wdata[15:8];
                end
            end
            ST_ARMED: begin
                if (cmd == CMD_DIRECT) begin
                    bank_we    = 1'b1;
                    bank_widx  = wdata[7:0];
                    bank_wdata = wdata[15:8];
                end else if (cmd == CMD_DATA_WR) begin
                    bank_we = 1'b1;
                end else if (cmd == CMD_DATA_RD) begin
                    rd_valid = 1'b1;
                end
            end
        endcase
    end

    // R5: one data access ends the armed period
    a_r5_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && (cmd == CMD_DATA_WR || cmd == CMD_DATA_RD))
        |=> state == ST_IDLE);

    // R6: stray data write reaches no register
    a_r6_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd == CMD_DATA_WR) |-> !bank_we);

    // R7: stray data read keeps the port unarmed
    a_r7_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd == CMD_DATA_RD) |=> state == ST_IDLE);

    // R12: newest index byte is the one held
    a_r12_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_IDX_SET |=> (state == ST_ARMED && idx_q == $past(wdata[7:0])));

    // R2: combined write leaves nothing armed
    a_r2_direct_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_DIRECT |=> state == ST_IDLE);

endmodule

// File: rtl/xreg_bank.sv
module xreg_bank
    import xreg_pkg::*;
#(
    parameter int NREGS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [7:0]         widx,
    input  logic [7:0]         wdata,
    input  logic [7:0]         ridx,
    output logic [7:0]         rdata,
    output logic [NREGS*8-1:0] regs_o
);
    localparam int         PW     = $clog2(NREGS);
    localparam logic [7:0] FIRST8 = 8'(WINDOW_END - NREGS);
    localparam logic [7:0] SIZE8  = 8'(NREGS);

    logic [7:0]    woff;
    logic [7:0]    roff;
    logic          whit;
    logic          rhit;
    logic [PW-1:0] wphys;
    logic [PW-1:0] rphys;
    logic [7:0]    reg_q [NREGS];

    // offsets wrap below the window, so one compare covers both ends
    always_comb begin
        woff  = widx - FIRST8;
        roff  = ridx - FIRST8;
        whit  = woff < SIZE8;
        rhit  = roff < SIZE8;
        wphys = woff[PW-1:0];
        rphys = roff[PW-1:0];
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                reg_q[i] <= 8'h00;
            else if (we && whit && wphys == PW'(i))
                reg_q[i] <= wdata;
        end

        assign regs_o[8*i +: 8] = reg_q[i];

        // R3: an accepted write lands in its own register
        a_r3_store: assert property (@(posedge clk) disable iff (!rst_n)
            (we && whit && wphys == PW'(i)) |=> regs_o[8*i +: 8] == $past(wdata));
    end

    always_comb begin
        rdata = NO_DATA;
        if (rhit)
            rdata = reg_q[rphys];
    end

    // R9: a write outside the window touches no register
    a_r9_miss_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !whit) |=> $stable(regs_o));

endmodule

// File: rtl/oneshot_xreg_port.sv
module oneshot_xreg_port
    import xreg_pkg::*;
#(
    parameter int NREGS    = 64,
    parameter bit ALT_BASE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        addr,
    input  logic [15:0]        wdata,
    input  logic [1:0]         be,
    input  logic               wr,
    input  logic               rd,
    output logic [7:0]         rdata,
    output logic [NREGS*8-1:0] regs_o
);
    localparam logic [15:0] BASE = ALT_BASE ? ALTERNATE_BASE : PRIMARY_BASE;

    host_cmd_e   cmd;
    port_state_e state;
    logic        bank_we;
    logic [7:0]  bank_widx;
    logic [7:0]  bank_wdata;
    logic        rd_valid;
    logic [7:0]  rd_idx;
    logic [7:0]  bank_rdata;

    xreg_decode #(.BASE(BASE)) u_decode (
        .addr (addr),
        .be   (be),
        .wr   (wr),
        .rd   (rd),
        .cmd  (cmd)
    );

    xreg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .wdata      (wdata),
        .state      (state),
        .bank_we    (bank_we),
        .bank_widx  (bank_widx),
        .bank_wdata (bank_wdata),
        .rd_valid   (rd_valid),
        .rd_idx     (rd_idx)
    );

    xreg_bank #(.NREGS(NREGS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bank_we),
        .widx   (bank_widx),
        .wdata  (bank_wdata),
        .ridx   (rd_idx),
        .rdata  (bank_rdata),
        .regs_o (regs_o)
    );

    assign rdata = rd_valid ? bank_rdata : NO_DATA;

    // R1: reads away from the data port see the idle value
    a_r1_other_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr != BASE + 16'd1) |-> rdata == NO_DATA);

    // R1: writes away from both ports leave the bank alone
    a_r1_other_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != BASE && addr != BASE + 16'd1) |=> $stable(regs_o));

    // R7: no armed index means the idle value on a data read
    a_r7_unarmed_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rd && !wr) |-> rdata == NO_DATA);

endmodule

// File: tb/oneshot_xreg_port_test.sv
module oneshot_xreg_port_test;
    localparam int N = 32;
    localparam logic [15:0] IDXP = 16'h01CE;
    localparam logic [15:0] DATP = 16'h01CF;
    localparam int FIRST = 192 - N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [15:0]     addr = '0;
    logic [15:0]     wdata = '0;
    logic [1:0]      be = '0;
    logic            wr = 1'b0;
    logic            rd = 1'b0;
    logic [7:0]      rdata;
    logic [N*8-1:0]  regs_o;

    logic [7:0] mem [N];
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    oneshot_xreg_port #(.NREGS(N), .ALT_BASE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .be(be),
        .wr(wr), .rd(rd), .rdata(rdata), .regs_o(regs_o)
    );

    function automatic logic [7:0] model_read(int idx);
        if (idx >= FIRST && idx < 192) return mem[idx - FIRST];
        return 8'hFF;
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_bank(string tag);
        int bad = -1;
        tests++;
        for (int p = 0; p < N; p++)
            if (bad < 0 && regs_o[8*p +: 8] !== mem[p]) bad = p;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: reg %0d actual %02h expected %02h",
                     tag, bad, regs_o[8*bad +: 8], mem[bad]);
        end
    endtask

    task automatic wr16(logic [15:0] a, logic [7:0] idx, logic [7:0] d);
        addr = a; wdata = {d, idx}; be = 2'b11; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; be = 2'b00;
    endtask

    task automatic wrb(logic [15:0] a, logic [7:0] d);
        addr = a; wdata = {8'h00, d}; be = 2'b01; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; be = 2'b00;
    endtask

    task automatic rdb(logic [15:0] a, output logic [7:0] v);
        addr = a; rd = 1'b1;
        #2 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int p = 0; p < N; p++) mem[p] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check_bank("R10 reset contents");
        rdb(DATP, v);
        check8("R10 R7 unarmed after reset", v, 8'hFF);

        // R2 R8 R9 R11: 16-bit write to every index
        for (int i = 0; i < 256; i++) begin
            wr16(IDXP, 8'(i), 8'(i) ^ 8'hA5);
            if (i >= FIRST && i < 192) mem[i - FIRST] = 8'(i) ^ 8'hA5;
        end
        check_bank("R2 R8 R9 R11 direct sweep");
        rdb(DATP, v);
        check8("R2 unarmed after direct write", v, 8'hFF);

        // R4 R5 R7 R8 R9: armed read of every index, then a second read
        for (int i = 0; i < 256; i++) begin
            wrb(IDXP, 8'(i));
            rdb(DATP, v);
            check8($sformatf("R4 R8 R9 read idx %02h", i), v, model_read(i));
            rdb(DATP, v);
            check8($sformatf("R5 R7 second read idx %02h", i), v, 8'hFF);
        end

        // R3 R6 R9: byte writes, then a stray second data write
        for (int i = 0; i < 256; i++) begin
            wrb(IDXP, 8'(i));
            wrb(DATP, ~8'(i));
            wrb(DATP, 8'h33);
            if (i >= FIRST && i < 192) mem[i - FIRST] = ~8'(i);
        end
        check_bank("R3 R6 R9 byte-write sweep");

        // R5: a read consumes the index, so the following write is dropped
        wrb(IDXP, 8'hB0);
        rdb(DATP, v);
        check8("R5 read before write", v, mem[192 - 16 - FIRST]);
        wrb(DATP, 8'h77);
        check_bank("R5 write after consuming read");

        // R5 R9: an out-of-range index is still consumed
        wrb(IDXP, 8'h10);
        wrb(DATP, 8'h55);
        wrb(DATP, 8'h66);
        check_bank("R5 R9 out-of-range consumed");

        // R12: re-arming replaces the index
        wrb(IDXP, 8'hA2);
        wrb(IDXP, 8'hBE);
        wrb(DATP, 8'h3C);
        mem[8'hBE - FIRST] = 8'h3C;
        check_bank("R12 rearm replaces index");
        wrb(IDXP, 8'hA2);
        rdb(DATP, v);
        check8("R12 first index untouched", v, mem[8'hA2 - FIRST]);

        // R8: last register of the bank sits at BF
        wrb(IDXP, 8'hBF);
        wrb(DATP, 8'hE1);
        mem[N-1] = 8'hE1;
        check8("R8 R11 top register lane", regs_o[8*(N-1) +: 8], 8'hE1);

        // R1: other addresses do nothing
        wr16(16'h03CE, 8'hB1, 8'h99);
        wrb(16'h01CD, 8'hB1);
        wrb(16'h01D0, 8'h99);
        check_bank("R1 foreign writes ignored");
        wrb(IDXP, 8'hB1);
        rdb(16'h01CE, v);
        check8("R1 read at index port", v, 8'hFF);
        rdb(16'h03CF, v);
        check8("R1 read at foreign data port", v, 8'hFF);
        rdb(DATP, v);
        check8("R1 index survives foreign reads", v, mem[8'hB1 - FIRST]);

        // R6: data write with nothing armed after reset-free idle
        wrb(DATP, 8'h42);
        check_bank("R6 stray write idle");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule